// File: doc/BRIEF.md
# Strobe-Handshake Bus Read Controller

This block pairs a requesting side and a responding side of a simple parallel read bus. The two sides share a request line, a wait line, a 12-bit address, an 8-bit data path, an enable line and a read/write select. A read begins when the requester sees `start` while idle. It latches the address and raises the request. From then on it counts a fixed access window of `WINDOW` clock cycles.

A responder that can answer inside that window drives its data and leaves the wait line low. The requester then samples the data bus when the window closes, which is plain strobe timing. A responder that needs longer raises wait straight away. It later drops wait in the same cycle that it drives the data, and the requester captures the data in the following cycle, which is handshake timing. If nothing answers, the requester still samples at the end of the window and returns the idle bus value.

The response delay of the responder is set by `srv_latency`. `srv_silent` makes the responder ignore requests, so the fallback path can be reached.

Top module: `strobe_read_bus`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `done`, `bus_req`, `bus_en`, `bus_wait` are low and `rd_data` and `bus_data` are 0.
- R2: A `start` seen while idle latches `addr_in` onto `bus_addr` and raises `bus_req` and `bus_en` with `bus_wr` = 0 (read). The request stays high until the cycle in which the data is captured, and it drops in that cycle.
- R3: The responder returns data = addr[7:0] XOR {addr[11:8], addr[11:8]} and holds it stable on `bus_data` while the request stays high. `bus_data` is 0 whenever the responder is not driving it.
- R4: With `srv_latency` <= `WINDOW`-2, `bus_wait` never rises, and `done` pulses exactly `WINDOW` cycles after the start edge, carrying the responder's data.
- R5: With `srv_latency` >= `WINDOW`-1, `bus_wait` is high one cycle after the start edge, which is before the window ends. It drops together with the data being driven. `done` comes `srv_latency`+2 cycles after the start edge and carries that data, and it is never produced while wait was high at the capture edge.
- R6: With `srv_silent` = 1, nothing answers, and the requester samples the bus at the window end: `done` comes `WINDOW` cycles after start with `rd_data` = 0.
- R7: A `start` arriving while a read is in flight is ignored. The read completes with the first address, and no further request follows.
- R8: The request is low for at least one cycle between reads. With `start` held high, the next read begins the cycle after `done`, and the responder serves it only after it has seen the request low.
- R9: `done` is a single-cycle pulse, and `rd_data` keeps the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read when idle |
| addr_in | input | 12 | Read address |
| srv_latency | input | 4 | Responder delay in cycles |
| srv_silent | input | 1 | Responder ignores requests |
| done | output | 1 | One-cycle pulse when data has been captured |
| rd_data | output | 8 | Captured read data |
| bus_req | output | 1 | Request line |
| bus_wait | output | 1 | Wait line from the responder |
| bus_en | output | 1 | Bus enable |
| bus_wr | output | 1 | Read/write select, 0 = read |
| bus_addr | output | 12 | Address lines |
| bus_data | output | 8 | Data lines driven by the responder |

## Verification
Several rules are checked on every cycle:
- Wait never stands without a request.
- The request holds until capture.
- A capture never happens while wait was high.
- `done` lasts one cycle.
- Held data stays stable.
- A fast latency never raises wait.

Only the bench scenarios can show the exact completion cycle for each latency, the value returned by a silent responder, and that an extra start during a read is dropped. The same applies to the request gap and the response order in back-to-back reads.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {M_IDLE, M_REQ, M_WAIT} mst_state_e;
    typedef enum logic [1:0] {S_IDLE, S_COUNT, S_HOLD} srv_state_e;

    typedef struct packed {
        logic  req;
        logic  en;
        logic  wr;
        addr_t addr;
    } bus_cmd_t;

    function automatic data_t srv_lookup(addr_t a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction
endpackage

// File: rtl/srb_window_cnt.sv
module srb_window_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (en && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
endmodule

// File: rtl/srb_master.sv
module srb_master
    import srb_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  addr_t    addr_i,
    input  logic     wait_i,
    input  data_t    data_i,
    output bus_cmd_t cmd_o,
    output logic     done_o,
    output data_t    rd_data_o
);
    mst_state_e state_q;
    addr_t      addr_q;
    logic       req_q;
    logic       done_q;
    data_t      rdata_q;
    logic       win_clr, win_en, win_expired;

    assign win_clr = (state_q == M_IDLE) && start_i;
    assign win_en  = (state_q == M_REQ);

    srb_window_cnt #(.LIMIT(WINDOW)) u_win (
        .clk(clk), .rst(rst), .clr(win_clr), .en(win_en), .expired(win_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_IDLE;
            addr_q  <= '0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                M_IDLE: if (start_i) begin
                    addr_q  <= addr_i;
                    req_q   <= 1'b1;
                    state_q <= M_REQ;
                end
                M_REQ: if (wait_i) begin
                    state_q <= M_WAIT;
                end else if (win_expired) begin
                    rdata_q <= data_i;
                    done_q  <= 1'b1;
                    req_q   <= 1'b0;
                    state_q <= M_IDLE;
                end
                M_WAIT: if (!wait_i) begin
                    rdata_q <= data_i;
                    done_q  <= 1'b1;
                    req_q   <= 1'b0;
                    state_q <= M_IDLE;
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    assign cmd_o     = '{req: req_q, en: req_q, wr: 1'b0, addr: addr_q};
    assign done_o    = done_q;
    assign rd_data_o = rdata_q;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst) req_q |=> (req_q || done_q));
    assert_no_capture_in_wait_R5: assert property (@(posedge clk) disable iff (rst) done_q |-> !$past(wait_i));
    assert_req_gap_R8: assert property (@(posedge clk) disable iff (rst) done_q |-> !req_q);
endmodule

// File: rtl/srb_servant.sv
module srb_servant
    import srb_pkg::*;
#(
    parameter int WINDOW = 4,
    parameter int LAT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic             silent_i,
    output logic             wait_o,
    output data_t            data_o
);
    localparam logic [LAT_W-1:0] FAST_MAX = LAT_W'(WINDOW - 2);

    srv_state_e       state_q;
    logic [LAT_W-1:0] lcnt_q;
    logic             wait_q;
    logic             drv_q;
    data_t            data_q;
    logic             accept;

    assign accept = cmd_i.req && cmd_i.en && !cmd_i.wr && !silent_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            lcnt_q  <= '0;
            wait_q  <= 1'b0;
            drv_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    if (lat_i == '0) begin
                        data_q  <= srv_lookup(cmd_i.addr);
                        drv_q   <= 1'b1;
                        state_q <= S_HOLD;
                    end else begin
                        lcnt_q  <= LAT_W'(1);
                        wait_q  <= (lat_i > FAST_MAX);
                        state_q <= S_COUNT;
                    end
                end
                S_COUNT: if (lcnt_q == lat_i) begin
                    data_q  <= srv_lookup(cmd_i.addr);
                    drv_q   <= 1'b1;
                    wait_q  <= 1'b0;
                    state_q <= S_HOLD;
                end else begin
                    lcnt_q <= lcnt_q + 1'b1;
                end
                S_HOLD: if (!cmd_i.req) begin
                    drv_q   <= 1'b0;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign wait_o = wait_q;
    assign data_o = drv_q ? data_q : '0;

    assert_wait_needs_req_R5: assert property (@(posedge clk) disable iff (rst) wait_q |-> cmd_i.req);
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (drv_q && cmd_i.req && state_q == S_HOLD) |=> $stable(data_o));
    assert_fast_no_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && accept && lat_i <= FAST_MAX) |=> !wait_q);
endmodule

// File: rtl/strobe_read_bus.sv
module strobe_read_bus
    import srb_pkg::*;
#(
    parameter int WINDOW = 4,
    parameter int LAT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [11:0]      addr_in,
    input  logic [LAT_W-1:0] srv_latency,
    input  logic             srv_silent,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             bus_req,
    output logic             bus_wait,
    output logic             bus_en,
    output logic             bus_wr,
    output logic [11:0]      bus_addr,
    output logic [7:0]       bus_data
);
    bus_cmd_t cmd;
    logic     wait_line;
    data_t    data_line;

    srb_master #(.WINDOW(WINDOW)) u_mst (
        .clk(clk), .rst(rst), .start_i(start), .addr_i(addr_in),
        .wait_i(wait_line), .data_i(data_line), .cmd_o(cmd),
        .done_o(done), .rd_data_o(rd_data)
    );

    srb_servant #(.WINDOW(WINDOW), .LAT_W(LAT_W)) u_srv (
        .clk(clk), .rst(rst), .cmd_i(cmd), .lat_i(srv_latency),
        .silent_i(srv_silent), .wait_o(wait_line), .data_o(data_line)
    );

    assign bus_req  = cmd.req;
    assign bus_en   = cmd.en;
    assign bus_wr   = cmd.wr;
    assign bus_addr = cmd.addr;
    assign bus_wait = wait_line;
    assign bus_data = data_line;
endmodule

// File: tb/sim_strobe_read_bus.sv
module sim_strobe_read_bus;
    localparam int WINDOW = 4;
    localparam int NVEC = 8;
    // {addr[11:0], latency[3:0], silent}
    localparam logic [16:0] VEC [NVEC] = '{
        {12'h3A5, 4'd0, 1'b0}, {12'hC17, 4'd1, 1'b0}, {12'h5F0, 4'd2, 1'b0},
        {12'h9E2, 4'd3, 1'b0}, {12'h1B4, 4'd5, 1'b0}, {12'h7C9, 4'd9, 1'b0},
        {12'hFFF, 4'd15, 1'b0}, {12'h2D6, 4'd1, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, srv_silent = 1'b0;
    logic [11:0] addr_in = '0;
    logic [3:0]  srv_latency = '0;
    logic done, bus_req, bus_wait, bus_en, bus_wr;
    logic [7:0] rd_data, bus_data;
    logic [11:0] bus_addr;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    strobe_read_bus #(.WINDOW(WINDOW)) u0 (
        .clk(clk), .rst(rst), .start(start), .addr_in(addr_in),
        .srv_latency(srv_latency), .srv_silent(srv_silent), .done(done),
        .rd_data(rd_data), .bus_req(bus_req), .bus_wait(bus_wait),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data)
    );

    function automatic logic [7:0] model_data(logic [11:0] a, logic s);
        return s ? 8'h00 : (a[7:0] ^ {a[11:8], a[11:8]});
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Starts one read at the current negedge; returns cycles until done.
    task automatic run_read(input logic [11:0] a, input logic [3:0] lat, input logic s,
                            output int cyc, output logic [7:0] dat,
                            output logic w_seen, output logic w_at1);
        addr_in = a; srv_latency = lat; srv_silent = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(bus_req && bus_en && !bus_wr && bus_addr == a, "R2 request raised", int'(bus_req), 1);
        cyc = 0; w_seen = 1'b0; w_at1 = 1'b0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (bus_wait) w_seen = 1'b1;
            if (cyc == 1) w_at1 = bus_wait;
        end
        dat = rd_data;
    endtask

    initial begin
        int cyc; logic [7:0] dat; logic ws, w1;
        repeat (3) @(negedge clk);
        check(!done && !bus_req && !bus_wait && !bus_en && rd_data == 0 && bus_data == 0,
              "R1 state in reset", int'(bus_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !bus_req && !bus_wait && rd_data == 0 && bus_data == 0,
              "R1 state after reset", int'(rd_data), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] a; logic [3:0] l; logic s, slow; int ecyc;
            {a, l, s} = VEC[i];
            slow = !s && (int'(l) >= WINDOW - 1);
            ecyc = slow ? int'(l) + 2 : WINDOW;
            run_read(a, l, s, cyc, dat, ws, w1);
            check(cyc == ecyc, s ? "R6 cycles" : (slow ? "R5 cycles" : "R4 cycles"), cyc, ecyc);
            check(dat == model_data(a, s), s ? "R6 data" : "R3 data", int'(dat), int'(model_data(a, s)));
            if (slow) check(w1 == 1'b1, "R5 wait early", int'(w1), 1);
            else      check(ws == 1'b0, "R4 no wait", int'(ws), 0);
            @(negedge clk);
            check(!done && rd_data == model_data(a, s), "R9 pulse and hold", int'(done), 0);
        end

        // R7: extra start mid-read ignored
        addr_in = 12'h4C3; srv_latency = 4'd1; srv_silent = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        addr_in = 12'hA0A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 40) begin @(negedge clk); cyc++; end
        check(rd_data == model_data(12'h4C3, 1'b0), "R7 first address kept", int'(rd_data),
              int'(model_data(12'h4C3, 1'b0)));
        repeat (3) @(negedge clk);
        check(!bus_req, "R7 no queued request", int'(bus_req), 0);

        // R8: back-to-back with start held high
        addr_in = 12'h136; srv_latency = 4'd3; start = 1'b1;
        @(negedge clk);
        cyc = 0;
        while (!done && cyc < 40) begin @(negedge clk); cyc++; end
        check(cyc == 5 && !bus_req, "R8 first read, request low at done", cyc, 5);
        addr_in = 12'h8E1;
        @(negedge clk);
        cyc++;
        check(bus_req && bus_addr == 12'h8E1, "R8 next request follows", int'(bus_req), 1);
        start = 1'b0;
        while (!done && cyc < 60) begin @(negedge clk); cyc++; end
        check(cyc == 11, "R8 second read timing", cyc, 11);
        check(rd_data == model_data(12'h8E1, 1'b0), "R8 second data", int'(rd_data),
              int'(model_data(12'h8E1, 1'b0)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule